// File: doc/BRIEF.md
# Serial ADC Host Controller with Start-up Sequencing

This block is the host side of a 16-clock serial link to a sampling converter. From the system clock it drives an active-low chip select, a divided serial clock that idles high, and the converter's serial data input. It also shifts in the converter's serial data output. Each frame sends a 12-bit control word, most significant bit first. In the same frame it collects a 16-bit result, most significant bit first. At the end of the frame the result is presented with a one-cycle valid strobe and a kind code.

After reset the block runs two start-up frames on its own. In these frames the data input stays high for the whole time chip select is low, and their results are tagged as dummy. Once both complete, `ready` rises. Software can then start a frame with a one-cycle `req` while `ready` is high. Setting `auto_en` instead lets a period counter start frames at a fixed rate. Between frames, chip select stays high for the rest of the period, which lets the converter power down. A running frame is only cut short by `abort_req`, and such a frame is reported as aborted.

The serial clock half-period is `cfg_half_div` system cycles. This value must be at least 1, and it is latched when a frame starts.

Top module: `adc_host_ctrl`

## Requirements
- R1: While `rst` is high, `cs_n`, `sclk` and `din` are 1, and `res_valid`, `ready` and `busy` are 0.
- R2: After reset, two start-up frames run without any request, with `din` held at 1 for as long as `cs_n` is low. `ready` stays 0 until both have completed in full.
- R3: Start-up frame results are reported with `res_kind` = 2'b01 (dummy) and never as 2'b00.
- R4: In a frame that is not aborted, `cs_n` stays low for exactly 33×H system cycles (H = half-period latched at the start). During that time `sclk` makes exactly 16 falling and 16 rising edges. The first fall comes H cycles after `cs_n` falls. `sclk` is 1 whenever `cs_n` is 1.
- R5: In a normal frame, `din` carries `ctrl_word[11]` from the moment `cs_n` falls and moves to the next lower bit on each rising `sclk` edge. At the falling edges 1 to 12 the converter therefore sees bits 11 down to 0, and at falls 13 to 16 it sees 0.
- R6: `dout` is sampled on each falling `sclk` edge, first bit into `res_data[15]`. `res_valid` is a single-cycle pulse in the cycle after `cs_n` rises. Normal frames report `res_kind` = 2'b00.
- R7: `req` starts a frame only when `ready` is 1. A `req` given while a frame runs starts nothing.
- R8: `abort_req` during a frame drives `cs_n` and `sclk` to 1 on the next clock edge and reports the frame with `res_kind` = 2'b10. `abort_req` while no frame runs has no effect.
- R9: With `auto_en` = 1, frame starts are spaced by `cfg_period` cycles when that is at least 34×H+2. Otherwise frames run back to back, with `cs_n` high for more than H cycles between them.
- R10: An aborted start-up frame does not count toward the two start-up frames. Two further complete dummy frames follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_half_div | input | DIV_W | Serial clock half-period in system cycles (>= 1) |
| cfg_period | input | PER_W | Frame start spacing in system cycles for paced mode |
| auto_en | input | 1 | Paced mode enable |
| ctrl_word | input | CTRL_BITS | Control word sent in the next frame |
| req | input | 1 | Start one frame (taken only while ready) |
| abort_req | input | 1 | Cut the running frame short |
| ready | output | 1 | Start-up done and idle, request accepted |
| busy | output | 1 | A frame is in progress |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock, idles high |
| din | output | 1 | Serial data to the converter |
| dout | input | 1 | Serial data from the converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | FRAME_BITS | Captured result word |
| res_kind | output | 2 | 00 normal, 01 dummy, 10 aborted |

## Verification
The assertions check the properties that hold on every cycle. `sclk` idles high outside a frame, and `din` stays high through start-up frames. Every frame that ends without an abort counts 16 falling edges. An abort releases the bus on the next edge. `res_valid` is a single pulse that follows a chip-select rise, and `ready` is never high during a frame. Some behaviours can only be shown by the bench scenarios, because they need a converter model and knowledge of what was sent. These are the bit order on `din` and `dout`, the exact chip-select length and setup time for each divider, the paced frame spacing, requests and aborts that are ignored, and the repeat of an aborted start-up frame.

// File: rtl/adc_host_pkg.sv
`timescale 1ns/1ps
package adc_host_pkg;
  typedef enum logic [1:0] {
    KIND_NORMAL = 2'b00,
    KIND_DUMMY  = 2'b01,
    KIND_ABORT  = 2'b10
  } res_kind_t;
endpackage

// File: rtl/adc_half_tick.sv
`timescale 1ns/1ps
// Emits a one-cycle tick every `half` cycles while enabled; restarts when disabled.
module adc_half_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt;

  assign tick = en && (cnt == half - ONE);

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + ONE;
  end
endmodule

// File: rtl/adc_frame_engine.sv
`timescale 1ns/1ps
// One frame: setup half-period, 16 fall/rise pairs, hold half-period.
// Even phases end in a falling edge (capture), odd phases in a rising edge (shift out).
module adc_frame_engine #(
  parameter int CTRL_BITS  = 12,
  parameter int FRAME_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  fill,
  input  logic [CTRL_BITS-1:0]  word,
  input  logic                  abort,
  input  logic                  tick,
  input  logic                  dout,
  output logic                  cs_n,
  output logic                  sclk,
  output logic                  din,
  output logic                  active,
  output logic                  done,
  output logic                  aborted,
  output logic [FRAME_BITS-1:0] data
);
  localparam int PH_LAST = 2 * FRAME_BITS;
  localparam int PH_W    = $clog2(PH_LAST + 1);

  logic [PH_W-1:0]       ph;
  logic [CTRL_BITS-1:0]  tx;
  logic [FRAME_BITS-1:0] rx;
  logic                  fill_r;

  always_ff @(posedge clk) begin
    done    <= 1'b0;
    aborted <= 1'b0;
    if (rst) begin
      active <= 1'b0;
      cs_n   <= 1'b1;
      sclk   <= 1'b1;
      din    <= 1'b1;
      ph     <= '0;
      tx     <= '0;
      rx     <= '0;
      data   <= '0;
      fill_r <= 1'b1;
    end else if (start && !active) begin
      active <= 1'b1;
      cs_n   <= 1'b0;
      sclk   <= 1'b1;
      fill_r <= fill;
      din    <= fill | word[CTRL_BITS-1];
      tx     <= fill ? {CTRL_BITS{1'b1}} : {word[CTRL_BITS-2:0], 1'b0};
      ph     <= '0;
      rx     <= '0;
    end else if (active && abort) begin
      active  <= 1'b0;
      cs_n    <= 1'b1;
      sclk    <= 1'b1;
      din     <= 1'b1;
      done    <= 1'b1;
      aborted <= 1'b1;
      data    <= rx;
    end else if (active && tick) begin
      ph <= ph + PH_W'(1);
      if (ph == PH_W'(PH_LAST)) begin
        active <= 1'b0;
        cs_n   <= 1'b1;
        din    <= 1'b1;
        done   <= 1'b1;
        data   <= rx;
      end else if (!ph[0]) begin
        sclk <= 1'b0;
        rx   <= {rx[FRAME_BITS-2:0], dout};
      end else begin
        sclk <= 1'b1;
        din  <= tx[CTRL_BITS-1];
        tx   <= {tx[CTRL_BITS-2:0], fill_r};
      end
    end
  end
endmodule

// File: rtl/adc_host_ctrl.sv
`timescale 1ns/1ps
module adc_host_ctrl
  import adc_host_pkg::*;
#(
  parameter int DIV_W        = 8,
  parameter int PER_W        = 16,
  parameter int CTRL_BITS    = 12,
  parameter int FRAME_BITS   = 16,
  parameter int DUMMY_FRAMES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [DIV_W-1:0]      cfg_half_div,
  input  logic [PER_W-1:0]      cfg_period,
  input  logic                  auto_en,
  input  logic [CTRL_BITS-1:0]  ctrl_word,
  input  logic                  req,
  input  logic                  abort_req,
  output logic                  ready,
  output logic                  busy,
  output logic                  cs_n,
  output logic                  sclk,
  output logic                  din,
  input  logic                  dout,
  output logic                  res_valid,
  output logic [FRAME_BITS-1:0] res_data,
  output logic [1:0]            res_kind
);
  localparam int DCW = $clog2(DUMMY_FRAMES + 1);

  logic                  eng_active, eng_done, eng_aborted, tick;
  logic [FRAME_BITS-1:0] eng_data;
  logic [DIV_W-1:0]      half_r, gap_cnt;
  logic [PER_W-1:0]      per_cnt;
  logic [DCW-1:0]        dummy_left;
  logic                  frm_dummy, idle_ok, init_done, launch;
  res_kind_t             kind_q;

  assign idle_ok   = !eng_active && !eng_done && (gap_cnt == '0);
  assign init_done = (dummy_left == '0);
  assign launch    = idle_ok && (!init_done || req || (auto_en && per_cnt == '0));
  assign ready     = idle_ok && init_done;
  assign busy      = eng_active;
  assign res_kind  = kind_q;

  // Start-up count, inter-frame gap and result register.
  always_ff @(posedge clk) begin
    if (rst) begin
      dummy_left <= DCW'(DUMMY_FRAMES);
      gap_cnt    <= '0;
      frm_dummy  <= 1'b0;
      half_r     <= DIV_W'(1);
      res_valid  <= 1'b0;
      res_data   <= '0;
      kind_q     <= KIND_NORMAL;
    end else begin
      res_valid <= eng_done;
      if (eng_done) begin
        res_data <= eng_data;
        kind_q   <= eng_aborted ? KIND_ABORT : (frm_dummy ? KIND_DUMMY : KIND_NORMAL);
        gap_cnt  <= half_r;
        if (frm_dummy && !eng_aborted && !init_done)
          dummy_left <= dummy_left - DCW'(1);
      end else if (gap_cnt != '0) begin
        gap_cnt <= gap_cnt - DIV_W'(1);
      end
      if (launch) begin
        frm_dummy <= !init_done;
        half_r    <= (cfg_half_div == '0) ? DIV_W'(1) : cfg_half_div;
      end
    end
  end

  // Throughput pacing: reloaded at every frame start.
  always_ff @(posedge clk) begin
    if (rst)                 per_cnt <= '0;
    else if (launch)         per_cnt <= (cfg_period == '0) ? '0 : cfg_period - PER_W'(1);
    else if (per_cnt != '0)  per_cnt <= per_cnt - PER_W'(1);
  end

  adc_half_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .en   (eng_active),
    .half (half_r),
    .tick (tick)
  );

  adc_frame_engine #(.CTRL_BITS(CTRL_BITS), .FRAME_BITS(FRAME_BITS)) u_eng (
    .clk     (clk),
    .rst     (rst),
    .start   (launch),
    .fill    (!init_done),
    .word    (ctrl_word),
    .abort   (abort_req),
    .tick    (tick),
    .dout    (dout),
    .cs_n    (cs_n),
    .sclk    (sclk),
    .din     (din),
    .active  (eng_active),
    .done    (eng_done),
    .aborted (eng_aborted),
    .data    (eng_data)
  );
endmodule

// File: rtl/adc_host_ctrl_chk.sv
`timescale 1ns/1ps
module adc_host_ctrl_chk #(
  parameter int FRAME_BITS = 16
) (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic sclk,
  input logic din,
  input logic abort_req,
  input logic res_valid,
  input logic ready,
  input logic frm_dummy
);
  localparam int FC_W = $clog2(FRAME_BITS + 1) + 1;

  logic            sclk_q, ab_seen;
  logic [FC_W-1:0] fcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q  <= 1'b1;
      fcnt    <= '0;
      ab_seen <= 1'b0;
    end else begin
      sclk_q <= sclk;
      if (cs_n)                 fcnt <= '0;
      else if (sclk_q && !sclk) fcnt <= fcnt + FC_W'(1);
      if (!cs_n && abort_req)   ab_seen <= 1'b1;
      else if (cs_n)            ab_seen <= 1'b0;
    end
  end

  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (rst) cs_n |-> sclk);
  p_full_frame_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(cs_n) && !ab_seen) |-> (fcnt == FC_W'(FRAME_BITS)));
  p_dummy_din_r2: assert property (@(posedge clk) disable iff (rst) (!cs_n && frm_dummy) |-> din);
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst) res_valid |=> !res_valid);
  p_valid_after_cs_r6: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ($past(cs_n) && !$past(cs_n, 2)));
  p_abort_release_r8: assert property (@(posedge clk) disable iff (rst)
    (abort_req && !cs_n) |=> (cs_n && sclk));
  p_ready_idle_r7: assert property (@(posedge clk) disable iff (rst) ready |-> cs_n);
endmodule

bind adc_host_ctrl adc_host_ctrl_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n      (cs_n),
  .sclk      (sclk),
  .din       (din),
  .abort_req (abort_req),
  .res_valid (res_valid),
  .ready     (ready),
  .frm_dummy (frm_dummy)
);

// File: tb/adc_host_ctrl_tb.sv
`timescale 1ns/1ps
module adc_host_ctrl_tb;
  localparam int DIV_W = 8;
  localparam int PER_W = 16;
  localparam int CW    = 12;
  localparam int FB    = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DIV_W-1:0] cfg_half_div = DIV_W'(2);
  logic [PER_W-1:0] cfg_period = '0;
  logic auto_en = 1'b0;
  logic [CW-1:0] ctrl_word = '0;
  logic req = 1'b0, abort_req = 1'b0;
  logic dout = 1'b0;
  logic ready, busy, cs_n, sclk, din, res_valid;
  logic [FB-1:0] res_data;
  logic [1:0] res_kind;

  int total = 0, fails = 0, cyc = 0, starts = 0, results = 0, good_dummy = 0;
  int falls, rises, cslen, setup, cs_rise_cyc = 0, last_start = -1, exp_gap = 0;
  bit seen_fall, prev_cs = 1'b1, prev_sclk = 1'b1, abort_sent = 1'b0, f_abort = 1'b0;
  bit auto_chk = 1'b0, done_flag = 1'b0;
  logic [FB-1:0] f_resp, sh, din_bits;
  logic [CW-1:0] f_ctrl;
  int f_half;

  always #2.5 clk = ~clk;

  adc_host_ctrl u_dut (
    .clk(clk), .rst(rst), .cfg_half_div(cfg_half_div), .cfg_period(cfg_period),
    .auto_en(auto_en), .ctrl_word(ctrl_word), .req(req), .abort_req(abort_req),
    .ready(ready), .busy(busy), .cs_n(cs_n), .sclk(sclk), .din(din), .dout(dout),
    .res_valid(res_valid), .res_data(res_data), .res_kind(res_kind)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  // Converter model and frame monitor, all sampled on the falling system clock.
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      prev_cs = 1'b1;
      prev_sclk = 1'b1;
    end else begin
      if (ready && good_dummy < 2) chk(0, "R2 ready before start-up done", 1, 0);
      if (prev_cs && !cs_n) begin
        starts++;
        f_resp = FB'($urandom);
        sh = f_resp;
        dout = sh[FB-1];
        f_ctrl = ctrl_word;
        f_half = int'(cfg_half_div);
        falls = 0; rises = 0; cslen = 0; setup = 0; seen_fall = 1'b0; din_bits = '0;
        if (auto_chk && last_start >= 0)
          chk(cyc - last_start == exp_gap, "R9 frame spacing", cyc - last_start, exp_gap);
        last_start = cyc;
      end
      if (!cs_n) begin
        cslen++;
        if (!seen_fall && sclk) setup++;
        if (prev_sclk && !sclk) begin
          falls++;
          seen_fall = 1'b1;
          din_bits = {din_bits[FB-2:0], din};
          sh = {sh[FB-2:0], 1'b0};
          dout = sh[FB-1];
        end
        if (!prev_sclk && sclk) rises++;
      end
      if (!prev_cs && cs_n) begin
        cs_rise_cyc = cyc;
        f_abort = abort_sent;
        abort_sent = 1'b0;
      end
      if (res_valid) begin
        results++;
        chk(cyc == cs_rise_cyc + 1, "R6 valid one cycle after cs rise", cyc, cs_rise_cyc + 1);
        if (f_abort) begin
          chk(res_kind == 2'b10, "R8 aborted kind", res_kind, 2'b10);
          chk(falls < FB, "R8 aborted frame shortened", falls, FB - 1);
        end else begin
          chk(falls == FB && rises == FB, "R4 sixteen fall/rise pairs", falls * 100 + rises, FB * 100 + FB);
          chk(cslen == 33 * f_half, "R4 cs low length", cslen, 33 * f_half);
          chk(setup == f_half, "R4 cs setup before first fall", setup, f_half);
          chk(res_data == f_resp, "R6 captured word", res_data, f_resp);
          if (good_dummy < 2) begin
            good_dummy++;
            chk(res_kind == 2'b01, "R3 dummy kind", res_kind, 2'b01);
            chk(din_bits == '1, "R2 din high in start-up frame", din_bits, 16'hFFFF);
          end else begin
            chk(res_kind == 2'b00, "R6 normal kind", res_kind, 2'b00);
            chk(din_bits == {f_ctrl, 4'b0000}, "R5 control bits on din", din_bits, {f_ctrl, 4'b0000});
          end
        end
      end
      prev_cs = cs_n;
      prev_sclk = sclk;
    end
  end

  task automatic wait_start();
    int s0 = starts;
    while (starts == s0) @(negedge clk);
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  task automatic do_frame(input int h, input logic [CW-1:0] w);
    int r0;
    wait_ready();
    cfg_half_div = DIV_W'(h);
    ctrl_word = w;
    r0 = results;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    while (results == r0) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL R6 watchdog act=hung exp=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(cs_n == 1'b1, "R1 cs_n in reset", cs_n, 1);
    chk(sclk == 1'b1, "R1 sclk in reset", sclk, 1);
    chk(din == 1'b1, "R1 din in reset", din, 1);
    chk(res_valid == 1'b0, "R1 res_valid in reset", res_valid, 0);
    chk(ready == 1'b0 && busy == 1'b0, "R1 ready/busy in reset", {ready, busy}, 0);
    rst = 1'b0;

    // R10: abort the first start-up frame
    wait_start();
    repeat (10) @(negedge clk);
    abort_req = 1'b1;
    abort_sent = 1'b1;
    @(negedge clk);
    abort_req = 1'b0;
    chk(cs_n && sclk, "R8 abort releases bus", {cs_n, sclk}, 2'b11);
    wait_ready();
    chk(good_dummy == 2 && results == 3, "R10 start-up repeated after abort", results, 3);

    // Directed corner words and dividers
    do_frame(1, 12'h000);
    do_frame(1, 12'hFFF);
    do_frame(4, 12'hA5C);
    do_frame(9, 12'h801);

    // R7: request while busy is ignored
    begin
      int s1;
      wait_ready();
      cfg_half_div = DIV_W'(2);
      ctrl_word = 12'h3C3;
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      repeat (5) @(negedge clk);
      chk(busy == 1'b1 && ready == 1'b0, "R7 busy during frame", {busy, ready}, 2'b10);
      ctrl_word = 12'h111;
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      s1 = starts;
      repeat (300) @(negedge clk);
      chk(starts == s1, "R7 request while busy ignored", starts, s1);
      chk(cs_n == 1'b1, "R7 bus idle afterwards", cs_n, 1);
    end

    // R8: abort while idle has no effect
    begin
      int r1;
      wait_ready();
      r1 = results;
      abort_req = 1'b1;
      @(negedge clk);
      abort_req = 1'b0;
      repeat (40) @(negedge clk);
      chk(results == r1 && cs_n, "R8 idle abort ignored", results, r1);
    end

    // R8: abort a normal frame, then a normal frame follows
    wait_ready();
    cfg_half_div = DIV_W'(2);
    ctrl_word = 12'h5AA;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    wait_start();
    repeat (1 + int'($urandom % 40)) @(negedge clk);
    abort_req = 1'b1;
    abort_sent = 1'b1;
    @(negedge clk);
    abort_req = 1'b0;
    chk(cs_n && sclk, "R8 abort releases bus", {cs_n, sclk}, 2'b11);
    do_frame(3, 12'h0F0);

    // Random frames
    for (int i = 0; i < 14; i++) do_frame(1 + int'($urandom % 4), CW'($urandom));

    // R9: paced frames, long period
    wait_ready();
    cfg_half_div = DIV_W'(1);
    cfg_period = PER_W'(120);
    ctrl_word = 12'h6B2;
    auto_en = 1'b1;
    wait_start();
    exp_gap = 120;
    auto_chk = 1'b1;
    for (int i = 0; i < 4; i++) wait_start();
    auto_chk = 1'b0;
    repeat (3) @(negedge clk);
    // R9: period shorter than a frame, back to back
    cfg_period = PER_W'(10);
    cfg_half_div = DIV_W'(2);
    wait_start();
    wait_start();
    exp_gap = 34 * 2 + 2;
    auto_chk = 1'b1;
    for (int i = 0; i < 3; i++) wait_start();
    auto_chk = 1'b0;
    auto_en = 1'b0;
    while (!(ready && results == starts)) @(negedge clk);

    chk(results == starts, "R6 every frame reported", results, starts);
    summary();
  end
endmodule